// File: doc/BRIEF.md
# Signature-Guarded Watchdog Timer

This block is a hardware watchdog that checks both that the monitored software is alive and that it is taking the expected path. A down-counter runs during normal operation, and the software has to restart it before it reaches zero. As the software passes checkpoints, it reports each checkpoint's identifier. The block folds every identifier into a running control-flow signature.

A restart request (kick) is accepted only when the folded signature equals a programmed reference value. Every kick that is evaluated clears the signature, so each interval between kicks is checked on its own.

Two kinds of failure are recorded in sticky error flags. One is the counter running out. The other is a kick whose signature disagrees with the reference. Both flags stay set until an explicit clear input is applied, and that clear also restarts the watchdog.

Top module: `sig_guard_wdog`

## Requirements
- R1: A synchronous reset loads the counter from `reload_val`, sets the signature to zero and clears both error flags.
- R2: The counter decrements by one on each clock and then holds at zero. On the first clock edge at which the counter is already zero, `timeout_err` is set. This means that with a reload value N and no accepted kick, `timeout_err` rises N+1 edges after the load.
- R3: A cycle with `cp_valid` high replaces the signature S with S rotated left by one bit, XOR the zero-extended `cp_id`. Because of the rotation, the same identifiers given in a different order give a different signature.
- R4: A kick whose folded signature equals `expect_sig` reloads the counter from `reload_val` and clears the signature.
- R5: A kick whose folded signature differs from `expect_sig` sets `sig_err`. It does not reload the counter, which keeps counting down, and it still clears the signature.
- R6: If a checkpoint and a kick arrive in the same cycle, the checkpoint is folded in first and the result is compared with `expect_sig`.
- R7: A kick that arrives while the counter is zero is ignored. It neither reloads the counter nor touches `sig_err` nor clears the signature, and any checkpoint in that cycle is still folded in.
- R8: `timeout_err` and `sig_err` stay set until `err_clear` is applied.
- R9: `err_clear` clears both flags, reloads the counter and zeroes the signature. It overrides a kick or a checkpoint in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_valid | input | 1 | A checkpoint identifier is present this cycle |
| cp_id | input | ID_W | Checkpoint identifier |
| kick | input | 1 | Restart request strobe |
| reload_val | input | CNT_W | Value loaded into the counter on reset, clear or an accepted kick |
| expect_sig | input | SIG_W | Reference signature for the kick comparison |
| err_clear | input | 1 | Clears the error flags and restarts the watchdog |
| timeout_err | output | 1 | Sticky flag: the counter reached zero |
| sig_err | output | 1 | Sticky flag: a kick carried a wrong signature |

## Verification
The bench builds the block with a 6-bit counter, an 8-bit signature and 4-bit identifiers. The narrow counter lets a timeout, the zero-count kick rule and the recovery after a clear all happen within a few dozen cycles. A signature that is wider than the identifiers exercises the zero-extension in the fold. An 8-bit signature is also short enough that rotation wraps after a few checkpoints, so checkpoint order matters in the checks. A behavioural model runs alongside the block, and both error flags are compared against it on every clock. This covers directed sequences and a long random mix of checkpoints, kicks with correct and wrong references, and clears.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        KICK_IDLE = 2'd0,
        KICK_PASS = 2'd1,
        KICK_FAIL = 2'd2
    } kick_verdict_e;

    typedef struct packed {
        logic timeout;
        logic sig_bad;
    } wdg_flags_t;

endpackage

// File: rtl/wdg_sig_accum.sv
module wdg_sig_accum
    import wdg_pkg::*;
#(
    parameter int SIG_W = 16,
    parameter int ID_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cp_valid,
    input  logic [ID_W-1:0]  cp_id,
    input  logic             judge,
    input  logic [SIG_W-1:0] expect_sig,
    output kick_verdict_e    verdict
);
    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] id_ext;
    logic [SIG_W-1:0] folded;

    generate
        if (ID_W >= SIG_W) begin : g_id_trunc
            assign id_ext = cp_id[SIG_W-1:0];
        end else begin : g_id_ext
            assign id_ext = {{(SIG_W-ID_W){1'b0}}, cp_id};
        end
    endgenerate

    always_comb begin
        folded = sig_q;
        if (cp_valid)
            folded = {sig_q[SIG_W-2:0], sig_q[SIG_W-1]} ^ id_ext;
    end

    always_comb begin
        verdict = KICK_IDLE;
        if (judge)
            verdict = (folded == expect_sig) ? KICK_PASS : KICK_FAIL;
    end

    always_ff @(posedge clk) begin
        if (rst || clr || judge)
            sig_q <= '0;
        else
            sig_q <= folded;
    end

    // The signature starts from zero after every evaluated kick (R4, R5).
    p_sig_cleared_after_kick_r4: assert property (@(posedge clk) disable iff (rst)
        judge |=> (sig_q == '0));

    // A clear zeroes the signature (R9).
    p_sig_cleared_by_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sig_q == '0));
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload_val,
    output logic             at_zero,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr || restart)
            count <= reload_val;
        else if (!at_zero)
            count <= count - ONE;
    end

    assign at_zero = (count == '0);

    // Once at zero, the counter stays there until a load (R2).
    p_hold_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (at_zero && !clr && !restart) |=> (count == '0));

    // A restart loads the reload value presented in that cycle (R4).
    p_restart_loads_r4: assert property (@(posedge clk) disable iff (rst)
        (restart && !clr) |=> (count == $past(reload_val)));
endmodule

// File: rtl/wdg_err_latch.sv
module wdg_err_latch
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       set_timeout,
    input  logic       set_sig,
    output wdg_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flags <= '0;
        end else begin
            flags.timeout <= flags.timeout | set_timeout;
            flags.sig_bad <= flags.sig_bad | set_sig;
        end
    end

    p_timeout_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flags.timeout && !clr) |=> flags.timeout);

    p_sig_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flags.sig_bad && !clr) |=> flags.sig_bad);

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (flags == '0));
endmodule

// File: rtl/sig_guard_wdog.sv
module sig_guard_wdog
    import wdg_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SIG_W = 16,
    parameter int ID_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cp_valid,
    input  logic [ID_W-1:0]  cp_id,
    input  logic             kick,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [SIG_W-1:0] expect_sig,
    input  logic             err_clear,
    output logic             timeout_err,
    output logic             sig_err
);
    kick_verdict_e    verdict;
    wdg_flags_t       flags;
    logic             at_zero;
    logic             judge;
    logic [CNT_W-1:0] count;

    // Kicks are only judged while the counter is still running and no clear is pending.
    assign judge = kick && !at_zero && !err_clear;

    wdg_sig_accum #(.SIG_W(SIG_W), .ID_W(ID_W)) u_sig (
        .clk        (clk),
        .rst        (rst),
        .clr        (err_clear),
        .cp_valid   (cp_valid),
        .cp_id      (cp_id),
        .judge      (judge),
        .expect_sig (expect_sig),
        .verdict    (verdict)
    );

    wdg_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .clr        (err_clear),
        .restart    (verdict == KICK_PASS),
        .reload_val (reload_val),
        .at_zero    (at_zero),
        .count      (count)
    );

    wdg_err_latch u_err (
        .clk         (clk),
        .rst         (rst),
        .clr         (err_clear),
        .set_timeout (at_zero),
        .set_sig     (verdict == KICK_FAIL),
        .flags       (flags)
    );

    assign timeout_err = flags.timeout;
    assign sig_err     = flags.sig_bad;

    // A rejected kick leaves the countdown running (R5).
    p_bad_kick_no_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (verdict == KICK_FAIL) |=> (count == $past(count) - CNT_W'(1)));

    // A kick at zero is never judged, so the counter stays at zero (R7).
    p_zero_kick_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (kick && at_zero && !err_clear) |=> (count == '0));

    // A bad kick always raises the signature flag on the next edge (R5).
    p_bad_kick_flags_r5: assert property (@(posedge clk) disable iff (rst)
        (verdict == KICK_FAIL) |=> sig_err);
endmodule

// File: tb/test_sig_guard_wdog.sv
module test_sig_guard_wdog;
    localparam int CW = 6;
    localparam int SW = 8;
    localparam int IW = 4;
    localparam int SMASK = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cp_valid = 1'b0;
    logic [IW-1:0] cp_id = '0;
    logic          kick = 1'b0;
    logic [CW-1:0] reload_val = CW'(12);
    logic [SW-1:0] expect_sig = '0;
    logic          err_clear = 1'b0;
    logic          timeout_err;
    logic          sig_err;

    always #4 clk = ~clk;

    sig_guard_wdog #(.CNT_W(CW), .SIG_W(SW), .ID_W(IW)) i_sig_guard_wdog (
        .clk(clk), .rst(rst), .cp_valid(cp_valid), .cp_id(cp_id), .kick(kick),
        .reload_val(reload_val), .expect_sig(expect_sig), .err_clear(err_clear),
        .timeout_err(timeout_err), .sig_err(sig_err)
    );

    // Behavioural reference model
    int m_cnt, m_sig;
    bit m_to, m_se;
    int vectors = 0, errors = 0, cycles = 0;
    string tag = "R1";

    function automatic int fold(int s, bit v, int id);
        if (!v) return s;
        return (((s * 2) + (s / (1 << (SW - 1)))) & SMASK) ^ id;
    endfunction

    always @(posedge clk) begin
        int f;
        bit z;
        cycles++;
        if (rst || err_clear) begin
            m_cnt = int'(reload_val); m_sig = 0; m_to = 0; m_se = 0;
        end else begin
            z = (m_cnt == 0);
            f = fold(m_sig, cp_valid, int'(cp_id));
            if (kick && !z) begin
                if (f == int'(expect_sig)) m_cnt = int'(reload_val);
                else begin m_se = 1; m_cnt = m_cnt - 1; end
                m_sig = 0;
            end else begin
                m_sig = f;
                if (!z) m_cnt = m_cnt - 1;
            end
            if (z) m_to = 1;
        end
    end

    task automatic compare();
        vectors++;
        if (timeout_err !== m_to || sig_err !== m_se) begin
            errors++;
            $display("FAIL %s: timeout_err/sig_err = %b/%b expected %b/%b at cycle %0d",
                     tag, timeout_err, sig_err, m_to, m_se, cycles);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        compare();
        cp_valid = 0; kick = 0; err_clear = 0; rst = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic cp(int id);
        cp_valid = 1; cp_id = IW'(id); tick();
    endtask

    // Kick with the correct reference (optionally with a checkpoint in the same cycle).
    task automatic good_kick(bit with_cp, int id);
        cp_valid = with_cp; cp_id = IW'(id);
        expect_sig = SW'(fold(m_sig, with_cp, id));
        kick = 1; tick();
    endtask

    task automatic flag_check(string t, bit eto, bit ese);
        vectors++;
        if (timeout_err !== eto || sig_err !== ese) begin
            errors++;
            $display("FAIL %s: flags %b/%b expected %b/%b", t, timeout_err, sig_err, eto, ese);
        end
    endtask

    initial begin
        #1;
        rst = 1; tick(); rst = 1; tick();
        tag = "R1"; idle(3); flag_check("R1", 0, 0);

        // R3/R4: checkpoints followed by a matching kick, repeated faster than the timeout
        tag = "R4";
        for (int k = 0; k < 4; k++) begin
            cp(3); cp(7); cp(5); idle(2); good_kick(0, 0); idle(3);
        end
        flag_check("R4", 0, 0);

        // R6: checkpoint and kick in the same cycle
        tag = "R6";
        cp(9); good_kick(1, 4); idle(2); flag_check("R6", 0, 0);

        // R3: reversed order gives a different signature -> R5 mismatch
        tag = "R3";
        cp(3); cp(7); cp(5);
        expect_sig = SW'(fold(fold(fold(0, 1, 5), 1, 7), 1, 3));
        kick = 1; tick();
        tag = "R5"; idle(2); flag_check("R5", 0, 1);

        // R8: sig_err remains through good kicks
        tag = "R8"; good_kick(0, 0); idle(4); flag_check("R8", 0, 1);

        // R9: clear overrides a same-cycle kick and checkpoint
        tag = "R9";
        err_clear = 1; kick = 1; cp_valid = 1; cp_id = 4'd2; expect_sig = 8'hAA; tick();
        idle(1); flag_check("R9", 0, 0);
        good_kick(0, 0); flag_check("R9", 0, 0);

        // R2: timeout after the reload runs out
        tag = "R2"; reload_val = CW'(5);
        good_kick(0, 0); idle(7); flag_check("R2", 1, 0);

        // R7: kick at zero with the correct reference does nothing
        tag = "R7"; good_kick(0, 0); idle(3); flag_check("R7", 1, 0);
        cp(6); expect_sig = SW'(fold(m_sig, 0, 0) ^ 1); kick = 1; tick();
        flag_check("R7", 1, 0);

        tag = "R8"; idle(5); flag_check("R8", 1, 0);
        tag = "R9"; reload_val = CW'(20); err_clear = 1; tick(); idle(2); flag_check("R9", 0, 0);

        // Random mix
        tag = "R3";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            reload_val = CW'($urandom_range(3, 30));
            cp_valid = ($urandom_range(0, 2) == 0);
            cp_id = IW'($urandom);
            if (r < 8) begin
                kick = 1;
                expect_sig = SW'(fold(m_sig, cp_valid, int'(cp_id)));
                if (r < 2) expect_sig = ~expect_sig;
            end else if (r == 50) begin
                err_clear = 1;
            end
            tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule